// File: doc/BRIEF.md
# Spread-Spectrum QPSK Baseband Modulator

This block turns a stream of data bits into shaped baseband I/Q samples for a direct-sequence spread-spectrum transmitter. Bits come either from an external source, one pair per symbol, or from an internal nine-stage pseudo-random generator that serves as a test pattern. Each rail is differentially encoded and then mapped to a signed amplitude. Every symbol is spread over eight chips by a fixed code. Each chip is zero-stuffed to four samples and passed through a 17-tap square-root raised cosine interpolation filter.

Software controls the block over an AXI4-Lite slave with two registers. One holds the enable and the source select. The other holds a rate divider that sets the number of clock cycles per output sample. Clearing the enable returns the whole datapath to its reset state, so every run starts from the same point.

Top module: `dsss_qpsk_mod`

## Requirements
- R1: After reset, `samp_valid_o` is 0, both sample outputs are 0, and reads of the control register (0x0) and the rate register (0x4) return 0.
- R2: The control register at 0x0 holds enable in bit 0 and source select in bit 1 (1 = internal generator). The rate register at 0x4 holds a 16-bit divider DIV. Writes honour the byte strobes. Reads of any other address return 0. Every response is OKAY (2'b00).
- R3: While enabled, one sample is produced every DIV+1 clock cycles. While disabled, no sample is produced.
- R4: Output sample n is the sum over j = 0..16 of h[j]·x[n−j], with x[m] = 0 for m < 0. The taps are h = −3, −12, −17, −8, 10, 40, 76, 108, 120, 108, 76, 40, 10, −8, −17, −12, −3. The result is exact, with no rounding.
- R5: x[m] is nonzero only when m mod 4 = 0. It then carries chip k = (m/4) mod 8 of symbol m/32. The chip sign is the encoded rail bit XOR bit k of the code 8'h6B, with chip 0 sent first.
- R6: A sign value of 0 maps to +10 and a sign value of 1 maps to −10, on I and Q alike.
- R7: Each rail is differentially encoded once per symbol as e = b XOR e_prev. The encoder memory is 0 when the block becomes enabled.
- R8: With the external source selected, `ext_take_o` pulses once per symbol. The dibit on `ext_dibit_i` is taken at that clock edge: bit 0 goes to the I rail and bit 1 to the Q rail. With the internal generator selected, `ext_take_o` stays low.
- R9: The internal generator is a 9-bit register seeded to 9'h1FF. It outputs bit 8 and shifts in bit 8 XOR bit 4 at the bottom. Its first output bit of a symbol goes to I and its second goes to Q.
- R10: Clearing the enable sets the outputs to zero and resets the encoder, the generator, the filter history and the sample counters. A later enable therefore reproduces the same stream.
- R11: Samples are 12-bit signed values, and `samp_valid_o` is high for one cycle per sample whenever DIV is at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s_axi_awaddr | input | 4 | Write address |
| s_axi_awvalid | input | 1 | Write address valid |
| s_axi_awready | output | 1 | Write address ready |
| s_axi_wdata | input | 32 | Write data |
| s_axi_wstrb | input | 4 | Write byte strobes |
| s_axi_wvalid | input | 1 | Write data valid |
| s_axi_wready | output | 1 | Write data ready |
| s_axi_bresp | output | 2 | Write response |
| s_axi_bvalid | output | 1 | Write response valid |
| s_axi_bready | input | 1 | Write response ready |
| s_axi_araddr | input | 4 | Read address |
| s_axi_arvalid | input | 1 | Read address valid |
| s_axi_arready | output | 1 | Read address ready |
| s_axi_rdata | output | 32 | Read data |
| s_axi_rresp | output | 2 | Read response |
| s_axi_rvalid | output | 1 | Read data valid |
| s_axi_rready | input | 1 | Read data ready |
| ext_dibit_i | input | 2 | External bit pair for the next symbol |
| ext_take_o | output | 1 | External bit pair consumed this cycle |
| samp_valid_o | output | 1 | Sample strobe |
| samp_i_o | output | 12 | In-phase sample, signed |
| samp_q_o | output | 12 | Quadrature sample, signed |

## Verification
The bench uses the default parameters: 12-bit output, amplitude 10, code 8'h6B and a 16-bit divider. It changes the divider at run time through the register interface. A divider of 0 exercises back-to-back samples. Dividers of 3 and 5 exercise single-cycle strobes and exact sample spacing. Runs of several symbols are long enough for the encoder to carry state across symbol boundaries and for the filter history to span chips from two symbols.

// File: rtl/dsss_pkg.sv
package dsss_pkg;

    localparam int SPS      = 4;
    localparam int CHIPS    = 8;
    localparam int NTAPS    = 17;
    localparam int SAMP_W   = $clog2(SPS * CHIPS);
    localparam int PH_W     = $clog2(SPS);
    localparam int PN_W     = 9;

    typedef struct packed {
        logic        enable;
        logic        src_prbs;
        logic [15:0] div;
    } mod_cfg_t;

    // symmetric square-root raised cosine taps, centre at index NTAPS/2
    function automatic int tap_coef(input int j);
        int k;
        k = (j <= NTAPS / 2) ? j : (NTAPS - 1 - j);
        case (k)
            0:       return -3;
            1:       return -12;
            2:       return -17;
            3:       return -8;
            4:       return 10;
            5:       return 40;
            6:       return 76;
            7:       return 108;
            default: return 120;
        endcase
    endfunction

    function automatic logic [PN_W-1:0] pn_step(input logic [PN_W-1:0] s);
        return {s[PN_W-2:0], s[8] ^ s[4]};
    endfunction

endpackage

// File: rtl/dsss_regs.sv
module dsss_regs
    import dsss_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [31:0]       wdata,
    input  logic [3:0]        wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic              bvalid,
    input  logic              bready,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [31:0]       rdata,
    output logic              rvalid,
    input  logic              rready,
    output mod_cfg_t          cfg_o
);

    typedef struct packed {
        mod_cfg_t    cfg;
        logic        bvalid;
        logic        rvalid;
        logic [31:0] rdata;
    } regs_t;

    regs_t q, d;
    logic  wr_go;

    always_comb begin
        d       = q;
        wr_go   = awvalid && wvalid && !q.bvalid;
        awready = wr_go;
        wready  = wr_go;
        arready = !q.rvalid;

        if (wr_go) begin
            d.bvalid = 1'b1;
            if (awaddr == ADDR_W'(0)) begin
                if (wstrb[0]) begin
                    d.cfg.enable   = wdata[0];
                    d.cfg.src_prbs = wdata[1];
                end
            end else if (awaddr == ADDR_W'(4)) begin
                for (int i = 0; i < 16; i++) begin
                    if (wstrb[i / 8]) d.cfg.div[i] = wdata[i];
                end
            end
        end else if (q.bvalid && bready) begin
            d.bvalid = 1'b0;
        end

        if (arvalid && !q.rvalid) begin
            d.rvalid = 1'b1;
            if (araddr == ADDR_W'(0))      d.rdata = {30'd0, q.cfg.src_prbs, q.cfg.enable};
            else if (araddr == ADDR_W'(4)) d.rdata = {16'd0, q.cfg.div};
            else                           d.rdata = 32'd0;
        end else if (q.rvalid && rready) begin
            d.rvalid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bvalid = q.bvalid;
    assign rvalid = q.rvalid;
    assign rdata  = q.rdata;
    assign cfg_o  = q.cfg;

    assert_bvalid_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);
    assert_rvalid_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));

endmodule

// File: rtl/dsss_symsrc.sv
module dsss_symsrc
    import dsss_pkg::*;
#(
    parameter logic [CHIPS-1:0] CODE = 8'h6B,
    parameter logic [PN_W-1:0]  SEED = 9'h1FF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  mod_cfg_t   cfg_i,
    input  logic [1:0] ext_dibit_i,
    output logic       ext_take_o,
    output logic       x_valid_o,
    output logic       x_nz_o,
    output logic [1:0] x_neg_o
);

    typedef struct packed {
        logic [15:0]       div_cnt;
        logic [SAMP_W-1:0] samp;
        logic [PN_W-1:0]   lfsr;
        logic [1:0]        enc;
        logic              xv;
        logic              xnz;
        logic [1:0]        xneg;
    } src_t;

    src_t       q, d;
    logic       tick, first;
    logic [1:0] bits, enc_new, enc_cur;
    logic       chip;

    always_comb begin
        d       = q;
        d.xv    = 1'b0;
        tick    = cfg_i.enable && (q.div_cnt >= cfg_i.div);
        first   = (q.samp == '0);
        bits    = cfg_i.src_prbs ? {q.lfsr[PN_W-2], q.lfsr[PN_W-1]} : ext_dibit_i;
        enc_new = bits ^ q.enc;
        enc_cur = first ? enc_new : q.enc;
        chip    = CODE[q.samp[SAMP_W-1:PH_W]];
        ext_take_o = tick && first && !cfg_i.src_prbs;

        if (!cfg_i.enable) begin
            d      = '0;
            d.lfsr = SEED;
        end else if (tick) begin
            d.div_cnt = '0;
            d.samp    = q.samp + 1'b1;
            if (first) begin
                d.enc = enc_new;
                if (cfg_i.src_prbs) d.lfsr = pn_step(pn_step(q.lfsr));
            end
            d.xv   = 1'b1;
            d.xnz  = (q.samp[PH_W-1:0] == '0);
            d.xneg = enc_cur ^ {chip, chip};
        end else begin
            d.div_cnt = q.div_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.lfsr <= SEED;
        end else begin
            q <= d;
        end
    end

    assign x_valid_o = q.xv;
    assign x_nz_o    = q.xnz;
    assign x_neg_o   = q.xneg;

    assert_pn_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.lfsr != '0);
    assert_enc_within_symbol_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !first) |=> $stable(q.enc));

endmodule

// File: rtl/dsss_shaper.sv
module dsss_shaper
    import dsss_pkg::*;
#(
    parameter int OUT_W = 12,
    parameter int AMP   = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    enable_i,
    input  logic                    x_valid_i,
    input  logic                    x_nz_i,
    input  logic [1:0]              x_neg_i,
    output logic                    out_valid_o,
    output logic signed [OUT_W-1:0] out_i_o,
    output logic signed [OUT_W-1:0] out_q_o
);

    localparam int PEAK = 186 * AMP;

    typedef struct packed {
        logic [NTAPS-1:0] nz;
        logic [NTAPS-1:0] ni;
        logic [NTAPS-1:0] nq;
        logic             ov;
        logic [OUT_W-1:0] oi;
        logic [OUT_W-1:0] oq;
    } shp_t;

    shp_t             q, d;
    logic [NTAPS-1:0] nz_n, ni_n, nq_n;
    int               acc_i, acc_q, t;

    always_comb begin
        d    = q;
        d.ov = 1'b0;
        nz_n = {q.nz[NTAPS-2:0], x_nz_i};
        ni_n = {q.ni[NTAPS-2:0], x_neg_i[0]};
        nq_n = {q.nq[NTAPS-2:0], x_neg_i[1]};
        acc_i = 0;
        acc_q = 0;
        t     = 0;
        for (int j = 0; j < NTAPS; j++) begin
            t = tap_coef(j) * AMP;
            if (nz_n[j]) begin
                acc_i = ni_n[j] ? acc_i - t : acc_i + t;
                acc_q = nq_n[j] ? acc_q - t : acc_q + t;
            end
        end
        if (!enable_i) begin
            d = '0;
        end else if (x_valid_i) begin
            d.nz = nz_n;
            d.ni = ni_n;
            d.nq = nq_n;
            d.ov = 1'b1;
            d.oi = OUT_W'(acc_i);
            d.oq = OUT_W'(acc_q);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid_o = q.ov;
    assign out_i_o     = q.oi;
    assign out_q_o     = q.oq;

    assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(x_valid_i));
    assert_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (int'(out_i_o) <= PEAK && int'(out_i_o) >= -PEAK &&
                         int'(out_q_o) <= PEAK && int'(out_q_o) >= -PEAK));

endmodule

// File: rtl/dsss_qpsk_mod.sv
module dsss_qpsk_mod
    import dsss_pkg::*;
#(
    parameter int               ADDR_W = 4,
    parameter int               OUT_W  = 12,
    parameter int               AMP    = 10,
    parameter logic [CHIPS-1:0] CODE   = 8'h6B,
    parameter logic [PN_W-1:0]  SEED   = 9'h1FF
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       s_axi_awaddr,
    input  logic                    s_axi_awvalid,
    output logic                    s_axi_awready,
    input  logic [31:0]             s_axi_wdata,
    input  logic [3:0]              s_axi_wstrb,
    input  logic                    s_axi_wvalid,
    output logic                    s_axi_wready,
    output logic [1:0]              s_axi_bresp,
    output logic                    s_axi_bvalid,
    input  logic                    s_axi_bready,
    input  logic [ADDR_W-1:0]       s_axi_araddr,
    input  logic                    s_axi_arvalid,
    output logic                    s_axi_arready,
    output logic [31:0]             s_axi_rdata,
    output logic [1:0]              s_axi_rresp,
    output logic                    s_axi_rvalid,
    input  logic                    s_axi_rready,
    input  logic [1:0]              ext_dibit_i,
    output logic                    ext_take_o,
    output logic                    samp_valid_o,
    output logic signed [OUT_W-1:0] samp_i_o,
    output logic signed [OUT_W-1:0] samp_q_o
);

    mod_cfg_t   cfg;
    logic       x_valid, x_nz;
    logic [1:0] x_neg;

    assign s_axi_bresp = 2'b00;
    assign s_axi_rresp = 2'b00;

    dsss_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .awaddr  (s_axi_awaddr),
        .awvalid (s_axi_awvalid),
        .awready (s_axi_awready),
        .wdata   (s_axi_wdata),
        .wstrb   (s_axi_wstrb),
        .wvalid  (s_axi_wvalid),
        .wready  (s_axi_wready),
        .bvalid  (s_axi_bvalid),
        .bready  (s_axi_bready),
        .araddr  (s_axi_araddr),
        .arvalid (s_axi_arvalid),
        .arready (s_axi_arready),
        .rdata   (s_axi_rdata),
        .rvalid  (s_axi_rvalid),
        .rready  (s_axi_rready),
        .cfg_o   (cfg)
    );

    dsss_symsrc #(.CODE(CODE), .SEED(SEED)) u_src (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_i       (cfg),
        .ext_dibit_i (ext_dibit_i),
        .ext_take_o  (ext_take_o),
        .x_valid_o   (x_valid),
        .x_nz_o      (x_nz),
        .x_neg_o     (x_neg)
    );

    dsss_shaper #(.OUT_W(OUT_W), .AMP(AMP)) u_shp (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable_i    (cfg.enable),
        .x_valid_i   (x_valid),
        .x_nz_i      (x_nz),
        .x_neg_i     (x_neg),
        .out_valid_o (samp_valid_o),
        .out_i_o     (samp_i_o),
        .out_q_o     (samp_q_o)
    );

endmodule

// File: tb/dsss_qpsk_mod_test.sv
module dsss_qpsk_mod_test;

    localparam logic [7:0] CODE = 8'h6B;
    localparam int         AMP  = 10;
    localparam int         MAXS = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  awaddr = '0, araddr = '0;
    logic        awvalid = 1'b0, wvalid = 1'b0, arvalid = 1'b0;
    logic        bready = 1'b1, rready = 1'b1;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;
    logic [1:0]  ext_dibit = '0;
    logic        ext_take, svalid;
    logic signed [11:0] si, sq;

    always #2.5 clk = ~clk;

    dsss_qpsk_mod uut (
        .clk(clk), .rst_n(rst_n),
        .s_axi_awaddr(awaddr), .s_axi_awvalid(awvalid), .s_axi_awready(awready),
        .s_axi_wdata(wdata), .s_axi_wstrb(wstrb), .s_axi_wvalid(wvalid), .s_axi_wready(wready),
        .s_axi_bresp(bresp), .s_axi_bvalid(bvalid), .s_axi_bready(bready),
        .s_axi_araddr(araddr), .s_axi_arvalid(arvalid), .s_axi_arready(arready),
        .s_axi_rdata(rdata), .s_axi_rresp(rresp), .s_axi_rvalid(rvalid), .s_axi_rready(rready),
        .ext_dibit_i(ext_dibit), .ext_take_o(ext_take),
        .samp_valid_o(svalid), .samp_i_o(si), .samp_q_o(sq)
    );

    int n_chk = 0, n_fail = 0;
    longint cyc = 0;
    int cap_n = 0, take_n = 0, ext_idx = 0, pat = 0;
    int got_i[MAXS], got_q[MAXS];
    longint got_t[MAXS];
    int enc_i[16], enc_q[16];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] dib(input int s, input int k);
        if (k == 0) return 2'd0;
        if (k == 1) return 2'd3;
        return 2'((s * 5 + 2) % 4);
    endfunction

    function automatic int tap(input int j);
        int h[9] = '{-3, -12, -17, -8, 10, 40, 76, 108, 120};
        return (j <= 8) ? h[j] : h[16 - j];
    endfunction

    function automatic int xval(input int m, input bit qr);
        int e, c;
        if (m < 0 || (m % 4) != 0) return 0;
        e = qr ? enc_q[m / 32] : enc_i[m / 32];
        c = CODE[(m / 4) % 8];
        return ((e ^ c) != 0) ? -AMP : AMP;
    endfunction

    function automatic int yexp(input int n, input bit qr);
        int acc = 0;
        for (int j = 0; j < 17; j++) acc += tap(j) * xval(n - j, qr);
        return acc;
    endfunction

    task automatic build_model(input bit prbs, input int k);
        logic [8:0] s = 9'h1FF;
        int ei = 0, eq = 0, bi, bq;
        for (int y = 0; y < 16; y++) begin
            if (prbs) begin
                bi = s[8]; s = {s[7:0], s[8] ^ s[4]};
                bq = s[8]; s = {s[7:0], s[8] ^ s[4]};
            end else begin
                bi = dib(y, k)[0];
                bq = dib(y, k)[1];
            end
            ei ^= bi; eq ^= bq;
            enc_i[y] = ei; enc_q[y] = eq;
        end
    endtask

    // clock counter, sample monitor and external bit driver
    initial forever begin
        @(negedge clk);
        cyc++;
        if (svalid && cap_n < MAXS) begin
            got_i[cap_n] = int'(si);
            got_q[cap_n] = int'(sq);
            got_t[cap_n] = cyc;
            cap_n++;
        end
    end

    initial begin
        bit seen = 1'b0;
        forever begin
            @(negedge clk);
            if (seen) ext_idx++;
            ext_dibit = dib(ext_idx, pat);
            seen = ext_take;
            if (ext_take) take_n++;
        end
    end

    task automatic axi_write(input logic [3:0] a, input logic [31:0] v, input logic [3:0] st);
        @(negedge clk);
        awaddr = a; wdata = v; wstrb = st; awvalid = 1'b1; wvalid = 1'b1;
        @(negedge clk);
        awvalid = 1'b0; wvalid = 1'b0;
        check(bvalid && bresp == 2'b00, "R2", "write response", {bvalid, bresp}, 4);
    endtask

    task automatic axi_read(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        araddr = a; arvalid = 1'b1;
        @(negedge clk);
        arvalid = 1'b0;
        v = rdata;
        check(rvalid && rresp == 2'b00, "R2", "read response", {rvalid, rresp}, 4);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check(!svalid && si == 0 && sq == 0, "R1", "outputs after reset", {svalid, si, sq}, 0);
        axi_read(4'h0, v); check(v == 0, "R1", "control after reset", v, 0);
        axi_read(4'h4, v); check(v == 0, "R1", "rate after reset", v, 0);
    endtask

    task automatic t_regs;
        logic [31:0] v;
        axi_write(4'h4, 32'hABCD_1234, 4'hF);
        axi_read(4'h4, v); check(v == 32'h1234, "R2", "rate readback", v, 32'h1234);
        axi_write(4'h4, 32'hFFFF_FF56, 4'h1);
        axi_read(4'h4, v); check(v == 32'h1256, "R2", "rate byte strobe", v, 32'h1256);
        axi_write(4'h0, 32'h0000_0002, 4'h1);
        axi_read(4'h0, v); check(v == 2, "R2", "control readback", v, 2);
        axi_write(4'h0, 32'h0000_0003, 4'h2);
        axi_read(4'h0, v); check(v == 2, "R2", "control strobe off", v, 2);
        axi_write(4'h8, 32'hFFFF_FFFF, 4'hF);
        axi_read(4'h8, v); check(v == 0, "R2", "unmapped read", v, 0);
        check(!svalid, "R3", "no samples while disabled", svalid, 0);
        axi_write(4'h0, 32'h0, 4'hF);
    endtask

    task automatic run_stream(input bit prbs, input int div, input int k,
                              input int nsamp, input string req);
        int bad = -1, gap_bad = -1, guard = 0, syms;
        axi_write(4'h0, 32'h0, 4'hF);
        axi_write(4'h4, 32'(div), 4'hF);
        repeat (4) @(negedge clk);
        pat = k; ext_idx = 0; cap_n = 0; take_n = 0;
        build_model(prbs, k);
        repeat (2) @(negedge clk);
        axi_write(4'h0, {30'd0, prbs, 1'b1}, 4'hF);
        while (cap_n < nsamp && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        axi_write(4'h0, 32'h0, 4'hF);
        check(cap_n >= nsamp, "R3", "sample count", cap_n, nsamp);
        for (int n = 0; n < cap_n; n++)
            if (bad < 0 && (got_i[n] != yexp(n, 0) || got_q[n] != yexp(n, 1))) bad = n;
        if (bad >= 0)
            check(1'b0, req, "sample I", got_i[bad], yexp(bad, 0));
        else
            check(1'b1, req, "stream", 0, 0);
        for (int n = 1; n < cap_n; n++)
            if (gap_bad < 0 && got_t[n] - got_t[n-1] != div + 1) gap_bad = n;
        check(gap_bad < 0, "R3 R11", "sample spacing",
              (gap_bad < 0) ? div + 1 : got_t[gap_bad] - got_t[gap_bad-1], div + 1);
        syms = (cap_n + 31) / 32;
        if (prbs) check(take_n == 0, "R8", "no take in generator mode", take_n, 0);
        else check(take_n >= syms && take_n <= syms + 1, "R8", "takes per symbol", take_n, syms);
    endtask

    task automatic t_idle;
        int cnt = 0;
        repeat (40) begin
            @(negedge clk);
            if (svalid || si != 0 || sq != 0) cnt++;
        end
        check(cnt == 0, "R10", "idle after disable", cnt, 0);
    endtask

    initial begin
        bit done = 1'b0;
        fork
            begin
                repeat (5) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_regs();
                run_stream(1'b0, 3, 0, 96,  "R5 R6");   // constant bits: code only
                run_stream(1'b0, 1, 1, 100, "R7");      // ones: encoder toggles
                run_stream(1'b0, 0, 2, 128, "R4 R8");   // mixed dibits, back-to-back
                run_stream(1'b1, 5, 0, 96,  "R9");      // generator source
                t_idle();
                run_stream(1'b1, 2, 0, 96,  "R10");     // restart gives same stream
                done = 1'b1;
            end
            begin
                repeat (150000) @(posedge clk);
                if (!done) begin
                    n_chk++; n_fail++;
                    $display("FAIL watchdog: actual timeout expected completion");
                end
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule